// File: doc/BRIEF.md
# Shared External Bus Arbitration Controller

This block lets one external bus be shared by two bus controllers through a three-wire handshake: a hold request, a hold acknowledge and a bus request. A single mode input decides which side of the handshake the block plays. As the bus owner (master mode) it drives the acknowledge line. As the borrower (slave mode) it reads the acknowledge line and drives the hold request. Two instances, one per mode, can therefore be wired pin to pin with no glue logic.

Toward the local bus sequencer the block takes a request and an idle flag, and it returns a grant. It also returns a float signal that tri-states the local bus drivers whenever the bus belongs to the other side. Hold and acknowledge inputs come from off-chip, so they pass through a parameterised synchronizer. The block commits every change of ownership, float state or acknowledge level only when the sequencer reports idle. A bus cycle that is under way is therefore never cut short.

Top module: `xbus_arbiter`

## Requirements
- R1: While arbitration is disabled (state after reset), the outputs are grant=1, float=0, breq_n=1, hlda_n=1, hlda_oe=0 and hold_n=1, whatever the hold, acknowledge, request and idle inputs are.
- R2: hlda_oe is 1 exactly while the block runs in master mode with arbitration enabled. In slave mode hlda_oe is 0.
- R3: In master mode, a low hold_n_i is seen after SYNC_STAGES rising edges. With idle high, the next edge hands the bus over: float=1, grant=0, hlda_n=0. With SYNC_STAGES=2 the change appears at the third edge after the input falls, and not at the second.
- R4: In master mode, a synchronized hold request is not acted on while idle is low. The handover happens at the first edge at which idle is high.
- R5: While the bus is handed over in master mode, breq_n equals the inverse of the local request, with no clock delay. breq_n is 1 in every other state.
- R6: In master mode, once hold_n_i returns high and passes the synchronizer, the bus is taken back: hlda_n=1, float=0, grant=1, breq_n=1.
- R7: In slave mode without the bus, float=1 and grant=0. A local request drives hold_n low at the next edge.
- R8: In slave mode, grant=1 and float=0 only after hlda_n_i low has passed the synchronizer (third edge after it falls). Until then hold_n stays low.
- R9: In slave mode with the bus, the bus is given up (hold_n=1, float=1, grant=0) at the first edge at which the local request is low and idle is high. It is not given up while idle is low.
- R10: After giving up the bus in slave mode, the block does not request again until hlda_n_i has been seen high through the synchronizer, even if the local request is already high.
- R11: Disable or mode change is acted on only while the block owns the bus in master mode (leaving it for slave mode needs idle high) or while it waits without the bus in slave mode. While the bus is handed over, a disable has no effect until the bus returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arb_en_i | input | 1 | Arbitration enable |
| slave_mode_i | input | 1 | 0 = master (owns bus, drives acknowledge), 1 = slave |
| hold_n_i | input | 1 | Hold request from the other controller, active low (master mode) |
| hlda_n_i | input | 1 | Hold acknowledge from the other controller, active low (slave mode) |
| loc_req_i | input | 1 | Local bus access pending |
| seq_idle_i | input | 1 | Local bus sequencer has no bus cycle in progress |
| breq_n_o | output | 1 | Bus request back to the holder, active low (master mode) |
| hlda_n_o | output | 1 | Hold acknowledge, active low (master mode) |
| hlda_oe_o | output | 1 | Acknowledge pin drive enable (1 = output) |
| hold_n_o | output | 1 | Hold request to the bus owner, active low (slave mode) |
| bus_float_o | output | 1 | Tri-state the local bus drivers |
| loc_gnt_o | output | 1 | Local sequencer may start bus cycles |

## Verification
The bench sweeps every combination of the four handshake inputs while arbitration is off. A design that leaked the hold input through too early would float the bus or drop the grant there. It measures the synchronizer latency to the edge, so an extra or missing flop fails. It also holds idle low for one to three cycles during a hold request: a design that ignored idle would float the bus in the middle of a cycle. The slave tests cover granting before the acknowledge is synchronized, releasing while busy, and re-requesting before the owner has dropped its acknowledge. A disable issued while the bus is lent out must not cut the handshake short.

// File: rtl/xbus_arb_pkg.sv
package xbus_arb_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_M_OWN  = 3'd1,
    ST_M_LENT = 3'd2,
    ST_S_WAIT = 3'd3,
    ST_S_ASK  = 3'd4,
    ST_S_HAVE = 3'd5,
    ST_S_DROP = 3'd6
  } arb_state_e;
endpackage

// File: rtl/xbus_rst_sync.sv
module xbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_sync.sv
module xbus_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{RST_VAL}};
      else        ff_q <= {ff_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/xbus_arb_fsm.sv
module xbus_arb_fsm
  import xbus_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arb_en_i,
  input  logic slave_mode_i,
  input  logic hold_n_s,
  input  logic hlda_n_s,
  input  logic loc_req_i,
  input  logic seq_idle_i,
  output logic breq_n_o,
  output logic hlda_n_o,
  output logic hlda_oe_o,
  output logic hold_n_o,
  output logic bus_float_o,
  output logic loc_gnt_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (arb_en_i) begin
          if (!slave_mode_i)   state_d = ST_M_OWN;
          else if (seq_idle_i) state_d = ST_S_WAIT;
        end
      end
      ST_M_OWN: begin
        if (!arb_en_i)                      state_d = ST_OFF;
        else if (slave_mode_i) begin
          if (seq_idle_i)                   state_d = ST_S_WAIT;
        end
        else if (!hold_n_s && seq_idle_i)   state_d = ST_M_LENT;
      end
      ST_M_LENT: begin
        if (hold_n_s) state_d = ST_M_OWN;
      end
      ST_S_WAIT: begin
        if (!arb_en_i)         state_d = ST_OFF;
        else if (!slave_mode_i) state_d = ST_M_OWN;
        else if (loc_req_i)     state_d = ST_S_ASK;
      end
      ST_S_ASK: begin
        if (!hlda_n_s) state_d = ST_S_HAVE;
      end
      ST_S_HAVE: begin
        if (!loc_req_i && seq_idle_i) state_d = ST_S_DROP;
      end
      ST_S_DROP: begin
        if (hlda_n_s) state_d = ST_S_WAIT;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_comb begin
    breq_n_o    = 1'b1;
    hlda_n_o    = 1'b1;
    hlda_oe_o   = 1'b0;
    hold_n_o    = 1'b1;
    bus_float_o = 1'b0;
    loc_gnt_o   = 1'b1;
    unique case (state_q)
      ST_OFF: ;
      ST_M_OWN: hlda_oe_o = 1'b1;
      ST_M_LENT: begin
        hlda_oe_o   = 1'b1;
        hlda_n_o    = 1'b0;
        breq_n_o    = !loc_req_i;
        bus_float_o = 1'b1;
        loc_gnt_o   = 1'b0;
      end
      ST_S_WAIT, ST_S_DROP: begin
        bus_float_o = 1'b1;
        loc_gnt_o   = 1'b0;
      end
      ST_S_ASK: begin
        hold_n_o    = 1'b0;
        bus_float_o = 1'b1;
        loc_gnt_o   = 1'b0;
      end
      ST_S_HAVE: hold_n_o = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_en_i,
  input  logic slave_mode_i,
  input  logic hold_n_i,
  input  logic hlda_n_i,
  input  logic loc_req_i,
  input  logic seq_idle_i,
  output logic breq_n_o,
  output logic hlda_n_o,
  output logic hlda_oe_o,
  output logic hold_n_o,
  output logic bus_float_o,
  output logic loc_gnt_o
);
  localparam int NUM_ASYNC = 2;

  logic                 rst_n_int;
  logic [NUM_ASYNC-1:0] pins_s;

  xbus_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  xbus_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({hlda_n_i, hold_n_i}),
    .q_o   (pins_s)
  );

  xbus_arb_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .arb_en_i     (arb_en_i),
    .slave_mode_i (slave_mode_i),
    .hold_n_s     (pins_s[0]),
    .hlda_n_s     (pins_s[1]),
    .loc_req_i    (loc_req_i),
    .seq_idle_i   (seq_idle_i),
    .breq_n_o     (breq_n_o),
    .hlda_n_o     (hlda_n_o),
    .hlda_oe_o    (hlda_oe_o),
    .hold_n_o     (hold_n_o),
    .bus_float_o  (bus_float_o),
    .loc_gnt_o    (loc_gnt_o)
  );
endmodule

// File: rtl/xbus_arbiter_chk.sv
module xbus_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic seq_idle_i,
  input logic loc_req_i,
  input logic breq_n_o,
  input logic hlda_n_o,
  input logic hlda_oe_o,
  input logic hold_n_o,
  input logic bus_float_o,
  input logic loc_gnt_o
);
  logic past_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  AST_ACK_MEANS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !hlda_n_o |-> (bus_float_o && !loc_gnt_o)); // R3

  AST_FLOAT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $rose(bus_float_o)) |-> $past(seq_idle_i)); // R4

  AST_BREQ_WHEN_LENT: assert property (@(posedge clk) disable iff (!rst_n)
    !breq_n_o |-> (!hlda_n_o && loc_req_i)); // R5

  AST_HOLD_OUT_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n_o |-> !hlda_oe_o); // R2

  AST_GNT_AFTER_ASK: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $rose(loc_gnt_o) && !hold_n_o) |-> $past(!hold_n_o)); // R8

  AST_NO_LEAVE_LENT: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && $fell(hlda_oe_o)) |-> $past(hlda_n_o)); // R11
endmodule

bind xbus_arbiter xbus_arbiter_chk i_chk (.*);

// File: tb/test_xbus_arbiter.sv
module test_xbus_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, arb_en_i, slave_mode_i, hold_n_i, hlda_n_i, loc_req_i, seq_idle_i;
  logic breq_n_o, hlda_n_o, hlda_oe_o, hold_n_o, bus_float_o, loc_gnt_o;
  int checks = 0;
  int fails  = 0;

  // output vector order: {gnt, float, breq_n, hlda_n, hlda_oe, hold_n}
  localparam logic [5:0] V_OFF  = 6'b101101;
  localparam logic [5:0] V_MOWN = 6'b101111;
  localparam logic [5:0] V_LENT = 6'b011011;
  localparam logic [5:0] V_SWT  = 6'b011101;
  localparam logic [5:0] V_SASK = 6'b011100;
  localparam logic [5:0] V_SHAV = 6'b101100;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_arbiter i_xbus_arbiter (.*);

  function automatic logic [5:0] outs();
    return {loc_gnt_o, bus_float_o, breq_n_o, hlda_n_o, hlda_oe_o, hold_n_o};
  endfunction

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, outs(), exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; arb_en_i = 0; slave_mode_i = 0; hold_n_i = 1; hlda_n_i = 1;
    loc_req_i = 0; seq_idle_i = 1;
    tick(2);
    chk("R1 reset", V_OFF);
    rst_n = 1;
    tick(4);
    chk("R1 after reset", V_OFF);

    // R1: disabled, sweep all input combos in both modes
    for (int m = 0; m < 32; m++) begin
      {slave_mode_i, hold_n_i, hlda_n_i, loc_req_i, seq_idle_i} = 5'(m);
      tick(3);
      chk("R1 disabled sweep", V_OFF);
    end
    hold_n_i = 1; hlda_n_i = 1; loc_req_i = 0; seq_idle_i = 1; slave_mode_i = 0;
    tick(3);

    // master mode
    arb_en_i = 1;
    tick(1);
    chk("R2 master enabled", V_MOWN);
    for (int d = 0; d < 4; d++) begin
      for (int r = 0; r < 2; r++) begin
        seq_idle_i = (d == 0);
        hold_n_i = 0;
        tick(2);
        chk("R3 latency not yet", V_MOWN);
        tick(1);
        for (int k = 0; k < d; k++) begin
          chk("R4 busy no handover", V_MOWN);
          tick(1);
        end
        if (d != 0) begin
          seq_idle_i = 1;
          tick(1);
        end
        chk("R3 handover", V_LENT);
        loc_req_i = r[0];
        #1;
        chk("R5 breq follows request", r[0] ? 6'b010011 : V_LENT);
        seq_idle_i = 0;
        tick(2);
        chk("R5 breq held", r[0] ? 6'b010011 : V_LENT);
        hold_n_i = 1;
        tick(2);
        chk("R6 not yet released", r[0] ? 6'b010011 : V_LENT);
        tick(1);
        chk("R6 bus back", V_MOWN);
        loc_req_i = 0; seq_idle_i = 1;
        tick(1);
      end
    end

    // R11: disable while lent has no effect until bus returns
    hold_n_i = 0;
    tick(3);
    chk("R11 lent", V_LENT);
    arb_en_i = 0; slave_mode_i = 1;
    tick(3);
    chk("R11 disable ignored while lent", V_LENT);
    hold_n_i = 1;
    tick(3);
    chk("R11 back to owner", V_MOWN);
    tick(1);
    chk("R11 disable taken", V_OFF);

    // R11: master to slave switch waits for idle
    arb_en_i = 1; slave_mode_i = 0;
    tick(1);
    chk("R2 master again", V_MOWN);
    slave_mode_i = 1; seq_idle_i = 0;
    tick(3);
    chk("R11 mode switch waits idle", V_MOWN);
    seq_idle_i = 1;
    tick(1);
    chk("R7 slave without bus", V_SWT);

    // slave sequence
    loc_req_i = 1;
    tick(1);
    chk("R7 hold asserted", V_SASK);
    hlda_n_i = 0;
    tick(2);
    chk("R8 not granted before sync", V_SASK);
    tick(1);
    chk("R8 granted", V_SHAV);
    loc_req_i = 0; seq_idle_i = 0;
    tick(3);
    chk("R9 busy keeps bus", V_SHAV);
    seq_idle_i = 1;
    tick(1);
    chk("R9 released", V_SWT);
    loc_req_i = 1;
    tick(4);
    chk("R10 no re-request while ack low", V_SWT);
    hlda_n_i = 1;
    tick(3);
    chk("R10 waiting after ack seen high", V_SWT);
    tick(1);
    chk("R10 re-request", V_SASK);
    hlda_n_i = 0;
    tick(3);
    chk("R8 second grant", V_SHAV);
    loc_req_i = 0;
    tick(1);
    chk("R9 second release", V_SWT);
    hlda_n_i = 1;
    tick(3);
    slave_mode_i = 0;
    tick(1);
    chk("R11 slave to master", V_MOWN);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule